// File: doc/BRIEF.md
# Accumulator Logical Shift-Right Unit

This block keeps a 40-bit accumulator together with a seven-bit status word. When the shift strobe is raised, the block moves the accumulator toward its least significant end by a count. Zeros enter at the top. In the same clock edge it rewrites the status word. Some status bits are forced low, some are computed from the new accumulator value, and the two sticky bits keep their previous values. The result is never saturated.

The count comes from one of two sources, chosen per operation. The immediate source is a 5-bit field. Counts from 0 to 16 are used as given, and any larger value is limited to 16. The register source is a 16-bit operand, and only its four lowest bits count, which gives 0 to 15. A load port writes the accumulator and the status word together, for example when a context is restored. A load wins over a shift that is requested in the same cycle. Every update becomes visible on the outputs one clock edge after the request.

Top module: `acc_shr_unit`

## Requirements
- R1: A shift makes the new accumulator equal the old value moved right by the effective count, with zeros entering from bit 39.
- R2: With the immediate source (`cnt_sel`=0), counts 0 to 16 are used as given, and any count from 17 to 31 acts as 16.
- R3: With the register source (`cnt_sel`=1), only `reg_opnd[3:0]` sets the count, and `reg_opnd[15:4]` has no effect.
- R4: A count of zero leaves the accumulator unchanged, but the status word is still rewritten.
- R5: After a shift, the overflow flag (`flags_q[6]`) and the carry flag (`flags_q[2]`) are 0.
- R6: After a shift, the zero flag (`flags_q[1]`) is 1 exactly when all 40 result bits are 0.
- R7: After a shift, the negative flag (`flags_q[0]`) equals bit 39 of the result.
- R8: A shift keeps the sticky-limit flag (`flags_q[5]`) and the sticky-overflow flag (`flags_q[3]`) at their previous values.
- R9: After a shift, the extension flag (`flags_q[4]`) is 1 exactly when result bits 39 down to 31 are not all equal.
- R10: A load writes `ld_acc` and `ld_flags` one edge later, and it wins over a shift strobe in the same cycle.
- R11: A cycle with neither load nor shift leaves the accumulator and the flags unchanged.
- R12: While reset is held, the accumulator and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Load strobe for the accumulator and flags |
| ld_acc | input | 40 | Accumulator value to load |
| ld_flags | input | 7 | Flag word to load (bit 6 overflow, 5 sticky limit, 4 extension, 3 sticky overflow, 2 carry, 1 zero, 0 negative) |
| shr_go | input | 1 | Shift request strobe |
| cnt_sel | input | 1 | Count source: 0 immediate, 1 register |
| imm_cnt | input | 5 | Immediate count |
| reg_opnd | input | 16 | Register operand; only bits 3:0 are used |
| acc_q | output | 40 | Accumulator |
| flags_q | output | 7 | Status word, same bit layout as `ld_flags` |

## Verification
The hardest flag to reach is the extension flag for a negative value that still fits in 32 bits. Bits 39 to 31 are then all ones, so the flag must be 0. Any non-zero shift clears bit 39, so only a zero-count shift of a loaded value can produce this case. The stimulus therefore loads values such as all ones in bits 39 to 31, a lone bit 31, and a lone bit 30, then shifts each by zero. Randomly mixed loads and shifts from both count sources, including immediate counts above 16, are compared with a reference model every cycle.

// File: rtl/acc_shr_pkg.sv
// Package acc_shr_pkg
// Purpose : shared status-word layout for the accumulator shift unit.
// Assumes : the bit order of flag_t matches the ld_flags/flags_q ports.
package acc_shr_pkg;

    localparam int FLAG_W = 7;

    typedef struct packed {
        logic ovf;         // bit 6
        logic sticky_lim;  // bit 5
        logic ext;         // bit 4
        logic sticky_ovf;  // bit 3
        logic carry;       // bit 2
        logic zero;        // bit 1
        logic neg;         // bit 0
    } flag_t;

endpackage

// File: rtl/shr_count_sel.sv
// Module  : shr_count_sel
// Purpose : picks the effective shift count from the immediate field or
//           from the low bits of a register operand, and limits the
//           immediate count to CNT_MAX.
// Assumes : CNT_W is wide enough for CNT_MAX, and REG_USE < CNT_W.
module shr_count_sel #(
    parameter int IMM_W   = 5,
    parameter int REG_W   = 16,
    parameter int REG_USE = 4,
    parameter int CNT_MAX = 16,
    parameter int CNT_W   = 5
) (
    input  logic               use_reg,
    input  logic [IMM_W-1:0]   imm_cnt,
    input  logic [REG_W-1:0]   reg_opnd,
    output logic [CNT_W-1:0]   eff_cnt
);
    logic [CNT_W-1:0] imm_lim;
    logic [CNT_W-1:0] reg_cnt;
    logic             unused_reg_hi;

    // limit an immediate count above the legal maximum
    always_comb begin
        if (imm_cnt > IMM_W'(CNT_MAX))
            imm_lim = CNT_W'(CNT_MAX);
        else
            imm_lim = CNT_W'(imm_cnt);
    end

    // zero-extend the used low bits of the register operand
    always_comb begin
        reg_cnt = '0;
        reg_cnt[REG_USE-1:0] = reg_opnd[REG_USE-1:0];
    end

    assign unused_reg_hi = ^reg_opnd[REG_W-1:REG_USE];

    // select the source
    always_comb eff_cnt = use_reg ? reg_cnt : imm_lim;

endmodule

// File: rtl/shr_barrel.sv
// Module  : shr_barrel
// Purpose : logical right shifter built as log2 stages; stage s moves
//           the data by 2**s when bit s of the count is set.
// Assumes : purely combinational; zeros enter from the top.
module shr_barrel #(
    parameter int W     = 40,
    parameter int CNT_W = 5
) (
    input  logic [W-1:0]     din,
    input  logic [CNT_W-1:0] cnt,
    output logic [W-1:0]     dout
);
    logic [W-1:0] stg [CNT_W+1];

    assign stg[0] = din;

    genvar s;
    generate
        for (s = 0; s < CNT_W; s++) begin : g_stage
            // one conditional power-of-two step
            assign stg[s+1] = cnt[s] ? (stg[s] >> (1 << s)) : stg[s];
        end
    endgenerate

    assign dout = stg[CNT_W];

endmodule

// File: rtl/shr_flag_gen.sv
// Module  : shr_flag_gen
// Purpose : builds the status word that follows a shift: overflow and
//           carry forced low, zero/negative/extension computed from the
//           result, sticky bits carried from the previous word.
// Assumes : the extension field is the top EXT_W bits of a W-bit value.
module shr_flag_gen
    import acc_shr_pkg::*;
#(
    parameter int W     = 40,
    parameter int EXT_W = 8
) (
    input  logic [W-1:0] res,
    input  flag_t        prev,
    output flag_t        nxt
);
    localparam int LOW = W - EXT_W - 1;

    logic [W-1:LOW] top_bits;

    assign top_bits = res[W-1:LOW];

    // compose the next status word
    always_comb begin
        nxt            = '0;
        nxt.ovf        = 1'b0;
        nxt.carry      = 1'b0;
        nxt.sticky_lim = prev.sticky_lim;
        nxt.sticky_ovf = prev.sticky_ovf;
        nxt.zero       = (res == '0);
        nxt.neg        = res[W-1];
        nxt.ext        = (|top_bits) && !(&top_bits);
    end

endmodule

// File: rtl/acc_shr_unit.sv
// Module  : acc_shr_unit
// Purpose : accumulator with a logical right shift and a status-word
//           update; a load writes accumulator and flags, and wins over
//           a shift in the same cycle.
// Assumes : synchronous active-low reset; results show one edge after
//           the request.
module acc_shr_unit
    import acc_shr_pkg::*;
#(
    parameter int ACC_W   = 40,
    parameter int EXT_W   = 8,
    parameter int IMM_W   = 5,
    parameter int REG_W   = 16,
    parameter int REG_USE = 4,
    parameter int CNT_MAX = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [ACC_W-1:0]   ld_acc,
    input  logic [FLAG_W-1:0]  ld_flags,
    input  logic               shr_go,
    input  logic               cnt_sel,
    input  logic [IMM_W-1:0]   imm_cnt,
    input  logic [REG_W-1:0]   reg_opnd,
    output logic [ACC_W-1:0]   acc_q,
    output logic [FLAG_W-1:0]  flags_q
);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    logic [ACC_W-1:0] acc_r;
    flag_t            flg_r;
    logic [CNT_W-1:0] eff_cnt;
    logic [ACC_W-1:0] shifted;
    flag_t            flg_nxt;

    shr_count_sel #(
        .IMM_W(IMM_W), .REG_W(REG_W), .REG_USE(REG_USE),
        .CNT_MAX(CNT_MAX), .CNT_W(CNT_W)
    ) u_cnt (
        .use_reg(cnt_sel), .imm_cnt(imm_cnt),
        .reg_opnd(reg_opnd), .eff_cnt(eff_cnt)
    );

    shr_barrel #(.W(ACC_W), .CNT_W(CNT_W)) u_shift (
        .din(acc_r), .cnt(eff_cnt), .dout(shifted)
    );

    shr_flag_gen #(.W(ACC_W), .EXT_W(EXT_W)) u_flags (
        .res(shifted), .prev(flg_r), .nxt(flg_nxt)
    );

    // state update: reset, then load, then shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r <= '0;
            flg_r <= '0;
        end else if (ld_en) begin
            acc_r <= ld_acc;
            flg_r <= flag_t'(ld_flags);
        end else if (shr_go) begin
            acc_r <= shifted;
            flg_r <= flg_nxt;
        end
    end

    assign acc_q   = acc_r;
    assign flags_q = flg_r;

    // count never exceeds the legal maximum
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eff_cnt <= CNT_W'(CNT_MAX));

    // a load takes effect and beats a shift
    assert_load_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (acc_q == $past(ld_acc)) && (flags_q == $past(ld_flags)));

    // idle cycle holds state
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !shr_go) |=> ($stable(acc_q) && $stable(flags_q)));

    // overflow and carry end low after a shift
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && shr_go) |=> (!flags_q[6] && !flags_q[2]));

    // zero flag follows the registered result
    assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && shr_go) |=> (flags_q[1] == (acc_q == '0)));

    // negative flag follows the top result bit
    assert_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && shr_go) |=> (flags_q[0] == acc_q[ACC_W-1]));

    // sticky bits survive a shift
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && shr_go) |=> ((flags_q[5] == $past(flags_q[5])) &&
                                (flags_q[3] == $past(flags_q[3]))));

    // zero count keeps the accumulator
    assert_cnt_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && shr_go && eff_cnt == '0) |=> $stable(acc_q));

    // a non-zero shift fills the top bit with zero
    assert_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && shr_go && eff_cnt != '0) |=> !acc_q[ACC_W-1]);

endmodule

// File: tb/acc_shr_unit_test.sv
`timescale 1ns/1ps
module acc_shr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [39:0] ld_acc = '0;
    logic [6:0]  ld_flags = '0;
    logic        shr_go = 1'b0;
    logic        cnt_sel = 1'b0;
    logic [4:0]  imm_cnt = '0;
    logic [15:0] reg_opnd = '0;
    logic [39:0] acc_q;
    logic [6:0]  flags_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [39:0] m_acc = '0;
    logic [6:0]  m_flg = '0;

    always #10 clk = ~clk;

    acc_shr_unit uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_acc(ld_acc),
        .ld_flags(ld_flags), .shr_go(shr_go), .cnt_sel(cnt_sel),
        .imm_cnt(imm_cnt), .reg_opnd(reg_opnd),
        .acc_q(acc_q), .flags_q(flags_q)
    );

    task automatic chk(input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at a falling edge, compare at the next one
    task automatic step(input logic ld, input logic [39:0] lv,
                        input logic [6:0] lf, input logic go,
                        input logic sel, input logic [4:0] imm,
                        input logic [15:0] rop, input string tag);
        logic [39:0] ea;
        logic [6:0]  ef;
        logic [39:0] r;
        int c;
        ld_en = ld; ld_acc = lv; ld_flags = lf; shr_go = go;
        cnt_sel = sel; imm_cnt = imm; reg_opnd = rop;
        if (ld) begin
            ea = lv; ef = lf;
        end else if (go) begin
            if (sel) c = int'(rop % 16);
            else c = (int'(imm) > 16) ? 16 : int'(imm);
            r  = m_acc >> c;
            ea = r;
            ef = {1'b0, m_flg[5],
                  (r[39:31] != 9'h000 && r[39:31] != 9'h1FF),
                  m_flg[3], 1'b0, (r == 40'd0), r[39]};
        end else begin
            ea = m_acc; ef = m_flg;
        end
        @(negedge clk);
        chk(tag, "acc", acc_q, ea);
        chk(tag, "flags", {33'd0, flags_q}, {33'd0, ef});
        m_acc = ea; m_flg = ef;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "reset acc", acc_q, 40'd0);
        chk("R12", "reset flags", {33'd0, flags_q}, 40'd0);
        rst_n = 1'b1;

        // R10 load with sticky bits set, then R1/R8 shift by immediate 4
        step(1, 40'h80_1234_5678, 7'h28, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd4, 0, "R1");
        step(0, 0, 0, 1, 0, 5'd1, 0, "R8");
        // R5: overflow and carry preset, then shifted away
        step(1, 40'hFF_FFFF_FFFF, 7'h7F, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd3, 0, "R5");
        // R2: 16 exact and clamped 20 and 31
        step(1, 40'hFF_FFFF_FFFF, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd16, 0, "R2");
        step(1, 40'hFF_FFFF_FFFF, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd20, 0, "R2");
        step(1, 40'hAB_CDEF_0123, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd31, 0, "R2");
        // R3: register source with noisy upper bits
        step(1, 40'hF0_0000_00F0, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 1, 5'd9, 16'hFFF3, "R3");
        step(0, 0, 0, 1, 1, 5'd0, 16'hABC0, "R3");
        // R4: count zero keeps value, flags rewritten
        step(1, 40'h80_0000_0000, 7'h44, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd0, 0, "R4");
        // R7: negative after zero shift already above; R6 zero result
        step(1, 40'h00_0000_FFFF, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd16, 0, "R6");
        step(1, 40'h80_0000_0001, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 1, 0, 16'h0010, "R7");
        // R9: extension corner cases through zero shifts
        step(1, 40'hFF_8000_0000, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd0, 0, "R9");
        step(1, 40'h00_8000_0000, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd0, 0, "R9");
        step(1, 40'h00_4000_0000, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd0, 0, "R9");
        step(1, 40'h01_0000_0000, 7'h00, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 5'd1, 0, "R9");
        // R10 load beats shift; R11 idle holds
        step(1, 40'h12_3456_789A, 7'h11, 1, 0, 5'd8, 0, "R10");
        step(0, 0, 0, 0, 0, 5'd8, 16'hFFFF, "R11");
        step(0, 0, 0, 0, 1, 5'd2, 16'h0005, "R11");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [39:0] v;
            k = $urandom_range(0, 7);
            v = {$urandom(), $urandom()} >> ($urandom_range(0, 1) * 24);
            if (k == 0)
                step(1, v, 7'($urandom()), $urandom_range(0, 1) == 1, 0,
                     5'($urandom()), 16'($urandom()), "R10");
            else if (k == 1)
                step(0, v, 0, 0, 1'($urandom()), 5'($urandom()),
                     16'($urandom()), "R11");
            else
                step(0, v, 0, 1, 1'($urandom()), 5'($urandom()),
                     16'($urandom()), "R1");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule